// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block collects up to eight interrupt request lines, holds them in a request register and filters them through a software mask. It then resolves them by fixed priority against the levels already being serviced, and raises a single interrupt line toward a processor. When the processor pulses the acknowledge input, the block returns an 8-bit vector and records the granted level as in service. The level stays in service until software retires it, unless the controller was set up to retire it by itself.

Software reaches the block over a byte-wide bus with chip select, one address bit, and read and write strobes. A write to the command port (address bit 0) either starts an initialization sequence or issues an operation command. Operation commands retire one level or choose which status register the command port returns on a read. The data port (address bit 1) takes the rest of the initialization words and otherwise holds the mask. A cascade identifier output reports the block's own position when it is set up as a subordinate controller.

Top module: `pic8_core`

## Requirements
- R1: After reset the mask register reads 0xFF, the request and in-service registers read 0x00, command-port reads return the request register, `intr` is low and `vec_vld` is low.
- R2: A command-port write with bit 4 set is the first setup word. It clears the request and in-service registers, points reads at the request register and keeps the mask. The following data-port writes are then taken in this order: the vector base; the cascade word, which is skipped when bit 1 of the first word is set; the mode word, which is skipped when bit 0 of the first word is clear. `intr` stays low until the last expected word has been taken.
- R3: Acknowledging a granted input n returns the vector base plus n.
- R4: With bit 3 of the first setup word clear, a request bit is set by a rising edge on its input, cleared when the input goes low, and cleared when it is acknowledged.
- R5: With bit 3 of the first setup word set, each request bit follows its input level one cycle later, and an acknowledge does not clear it.
- R6: Outside the setup sequence a data-port write loads the mask, and a data-port read returns it. A masked input is still latched in the request register but never raises `intr`.
- R7: Input 0 has the highest priority. `intr` is asserted only when the highest-priority unmasked pending input is strictly higher than every in-service level.
- R8: Without automatic retirement, an acknowledge sets the in-service bit of the granted input and `intr` falls.
- R9: A command-port write of 0x60 plus n clears in-service bit n and no other bit.
- R10: A command-port write of 0x0A selects the request register and 0x0B selects the in-service register for later command-port reads. The choice persists, and a status command with bit 1 clear (such as 0x08) leaves it unchanged.
- R11: When bit 1 of the mode word is set, an acknowledge sets no in-service bit.
- R12: An acknowledge that arrives when no input qualifies returns the vector base plus 7 and changes no in-service bit. This holds even when input 7 is masked.
- R13: `cas_id` shows bits 2:0 of the cascade word when `is_master` is low and 0 when it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| a0 | input | 1 | Port select: 0 command, 1 data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, one cycle per write |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not reading |
| ir | input | 8 | Interrupt request inputs, synchronous to clk |
| ack | input | 1 | Acknowledge pulse, one cycle |
| is_master | input | 1 | High for a master controller, low for a subordinate |
| intr | output | 1 | Interrupt request to the processor |
| vec | output | 8 | Vector returned for the last acknowledge |
| vec_vld | output | 1 | High for one cycle after an acknowledge |
| cas_id | output | 3 | Own cascade identifier |

## Verification
The assertions take for granted that the request inputs are already synchronous to the clock. They also assume that each write strobe lasts exactly one cycle and that `ack` is a single-cycle pulse that never coincides with a bus write. The bench drives every input on the falling clock edge, gives each bus access and each acknowledge one cycle and then releases it, and holds reset for several cycles before starting. That stimulus makes the one-cycle look-backs in the properties meaningful. The spurious case is produced by dropping a request after `intr` has risen and acknowledging one cycle later.

// File: rtl/pic8_pkg.sv
// pic8_pkg: shared constants, types and helpers for the interrupt controller.
// Assumes a byte-wide bus and eight request lines.
package pic8_pkg;
    localparam int unsigned NLINES = 8;
    localparam int unsigned LVL_W  = $clog2(NLINES);
    localparam int unsigned DW     = 8;

    // bit positions inside the first setup word
    localparam int unsigned S1_INIT  = 4;
    localparam int unsigned S1_LEVEL = 3;
    localparam int unsigned S1_NOCAS = 1;
    localparam int unsigned S1_WANT4 = 0;
    // bit positions inside the mode word and status command
    localparam int unsigned S4_AUTO  = 1;
    localparam int unsigned OC_STAT  = 3;
    localparam int unsigned OC_RSVLD = 1;
    localparam int unsigned OC_RSISR = 0;
    localparam logic [2:0]  OC_SPEOI = 3'b011;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_BASE,
        SEQ_CASC,
        SEQ_MODE,
        SEQ_RUN
    } seq_t;

    // Lowest set index of v, with a found flag in the top bit.
    function automatic logic [LVL_W:0] first_set(input logic [NLINES-1:0] v);
        logic [LVL_W:0] r;
        r = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (v[i]) r = {1'b1, LVL_W'(i)};
        end
        return r;
    endfunction

    // One-hot decode of a level number.
    function automatic logic [NLINES-1:0] lvl_bit(input logic [LVL_W-1:0] n);
        return NLINES'(1) << n;
    endfunction
endpackage

// File: rtl/pic8_regif.sv
// pic8_regif: bus decode, setup-word sequencer, mask register, read select
// and operation-command decode. Assumes single-cycle write strobes.
module pic8_regif
    import pic8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              a0,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DW-1:0]     din,
    input  logic [NLINES-1:0] irr,
    input  logic [NLINES-1:0] isr,
    input  logic              is_master,
    output logic [DW-1:0]     rd_data,
    output logic [NLINES-1:0] imr,
    output logic [DW-1:0]     vec_base,
    output logic              auto_eoi,
    output logic              lvl_mode,
    output logic              ready,
    output logic              init_pulse,
    output logic              eoi_pulse,
    output logic [LVL_W-1:0]  eoi_lvl,
    output logic [LVL_W-1:0]  cas_id
);
    seq_t             seq;
    logic             want4;
    logic             nocas;
    logic             rd_isr;
    logic [LVL_W-1:0] casc;
    logic             wr_cmd;
    logic             wr_dat;
    logic             stat_cmd;

    // decode of bus strobes into port writes
    always_comb begin
        wr_cmd     = !cs_n && !wr_n && !a0;
        wr_dat     = !cs_n && !wr_n &&  a0;
        init_pulse = wr_cmd && din[S1_INIT];
        stat_cmd   = wr_cmd && !din[S1_INIT] && din[OC_STAT];
        eoi_pulse  = wr_cmd && !din[S1_INIT] && !din[OC_STAT]
                     && (din[7:5] == OC_SPEOI);
        eoi_lvl    = din[LVL_W-1:0];
        ready      = (seq == SEQ_RUN);
        cas_id     = is_master ? '0 : casc;
    end

    // read multiplexer for both ports
    always_comb begin
        if (cs_n || rd_n)  rd_data = '0;
        else if (a0)       rd_data = imr;
        else if (rd_isr)   rd_data = isr;
        else               rd_data = irr;
    end

    // setup sequencer and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq      <= SEQ_IDLE;
            imr      <= '1;
            vec_base <= '0;
            casc     <= '0;
            auto_eoi <= 1'b0;
            lvl_mode <= 1'b0;
            want4    <= 1'b0;
            nocas    <= 1'b0;
            rd_isr   <= 1'b0;
        end else if (init_pulse) begin
            seq      <= SEQ_BASE;
            lvl_mode <= din[S1_LEVEL];
            nocas    <= din[S1_NOCAS];
            want4    <= din[S1_WANT4];
            auto_eoi <= 1'b0;
            rd_isr   <= 1'b0;
        end else if (stat_cmd) begin
            if (din[OC_RSVLD]) rd_isr <= din[OC_RSISR];
        end else if (wr_dat) begin
            case (seq)
                SEQ_BASE: begin
                    vec_base <= din;
                    if (!nocas)     seq <= SEQ_CASC;
                    else if (want4) seq <= SEQ_MODE;
                    else            seq <= SEQ_RUN;
                end
                SEQ_CASC: begin
                    casc <= din[LVL_W-1:0];
                    seq  <= want4 ? SEQ_MODE : SEQ_RUN;
                end
                SEQ_MODE: begin
                    auto_eoi <= din[S4_AUTO];
                    seq      <= SEQ_RUN;
                end
                default: imr <= din;
            endcase
        end
    end

    // R6: a data write outside the sequence lands in the mask
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dat && (seq == SEQ_IDLE || seq == SEQ_RUN)) |=> (imr == $past(din)));

    // R10: a status command without the select bit keeps the read choice
    a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_cmd && !din[OC_RSVLD]) |=> $stable(rd_isr));

    // R2: the first setup word always restarts the sequence
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (seq == SEQ_BASE));
endmodule

// File: rtl/pic8_irr.sv
// pic8_irr: request register with edge or level capture.
// Assumes ir is synchronous to clk; ack_clr is one-hot or zero.
module pic8_irr
    import pic8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] ir,
    input  logic              lvl_mode,
    input  logic              clr_all,
    input  logic [NLINES-1:0] ack_clr,
    output logic [NLINES-1:0] irr
);
    logic [NLINES-1:0] ir_prev;

    // per-line capture of requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr     <= '0;
            ir_prev <= '0;
        end else begin
            ir_prev <= ir;
            if (clr_all)       irr <= '0;
            else if (lvl_mode) irr <= ir;
            else               irr <= (irr | (ir & ~ir_prev)) & ir & ~ack_clr;
        end
    end

    // R4: a newly set request bit needs its input high the cycle before
    a_r4_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr & ~$past(irr) & ~$past(ir)) == '0));
endmodule

// File: rtl/pic8_arb.sv
// pic8_arb: fixed-priority resolution, in-service register, acknowledge
// and vector generation. Assumes ack is a single-cycle pulse.
module pic8_arb
    import pic8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irr,
    input  logic [NLINES-1:0] imr,
    input  logic              ready,
    input  logic              ack,
    input  logic              auto_eoi,
    input  logic [DW-1:0]     vec_base,
    input  logic              init_pulse,
    input  logic              eoi_pulse,
    input  logic [LVL_W-1:0]  eoi_lvl,
    output logic [NLINES-1:0] isr,
    output logic [NLINES-1:0] ack_clr,
    output logic              intr,
    output logic [DW-1:0]     vec,
    output logic              vec_vld
);
    localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(NLINES - 1);

    logic [LVL_W:0]    p_sel;
    logic [LVL_W:0]    s_sel;
    logic              grant_ok;
    logic              ack_take;
    logic [LVL_W-1:0]  grant_lvl;
    logic [NLINES-1:0] isr_next;

    // priority resolution against the in-service levels
    always_comb begin
        p_sel     = first_set(irr & ~imr);
        s_sel     = first_set(isr);
        grant_ok  = ready && p_sel[LVL_W]
                    && (!s_sel[LVL_W] || (p_sel[LVL_W-1:0] < s_sel[LVL_W-1:0]));
        ack_take  = ack && grant_ok;
        grant_lvl = ack_take ? p_sel[LVL_W-1:0] : SPUR_LVL;
        ack_clr   = ack_take ? lvl_bit(p_sel[LVL_W-1:0]) : '0;
    end

    // next in-service value from retirement and grant
    always_comb begin
        isr_next = isr;
        if (eoi_pulse)            isr_next = isr_next & ~lvl_bit(eoi_lvl);
        if (ack_take && !auto_eoi) isr_next = isr_next | ack_clr;
        if (init_pulse)           isr_next = '0;
    end

    // registered state and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr     <= '0;
            intr    <= 1'b0;
            vec     <= '0;
            vec_vld <= 1'b0;
        end else begin
            isr     <= isr_next;
            intr    <= grant_ok && !ack && !init_pulse;
            vec_vld <= ack;
            if (ack) vec <= vec_base + {{(DW-LVL_W){1'b0}}, grant_lvl};
        end
    end

    // R2: no interrupt before setup completes
    a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !intr);

    // R8: an in-service bit only appears after an acknowledge
    a_r8_set_by_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr & ~$past(isr)) != '0) |-> $past(ack));

    // R8: at most one new in-service bit per cycle
    a_r8_one_new: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr & ~$past(isr)));

    // R11: automatic retirement sets nothing in service
    a_r11_auto: assert property (@(posedge clk) disable iff (!rst_n)
        $past(auto_eoi) |-> ((isr & ~$past(isr)) == '0));

    // R9: specific retirement clears its level
    a_r9_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && !ack) |=> !isr[$past(eoi_lvl)]);

    // R12: an unqualified acknowledge yields the lowest-priority vector
    a_r12_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !grant_ok) |=> (vec == $past(vec_base) + DW'(NLINES - 1)));

    // R3: vector valid only right after an acknowledge
    a_r3_vld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> $past(ack));
endmodule

// File: rtl/pic8_core.sv
// pic8_core: top of the eight-input interrupt controller. Ties together the
// bus/setup front end, the request register and the priority arbiter.
// Assumes all inputs are synchronous to clk.
module pic8_core
    import pic8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              a0,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    input  logic [NLINES-1:0] ir,
    input  logic              ack,
    input  logic              is_master,
    output logic              intr,
    output logic [DW-1:0]     vec,
    output logic              vec_vld,
    output logic [LVL_W-1:0]  cas_id
);
    logic [NLINES-1:0] irr;
    logic [NLINES-1:0] isr;
    logic [NLINES-1:0] imr;
    logic [NLINES-1:0] ack_clr;
    logic [DW-1:0]     vec_base;
    logic              auto_eoi;
    logic              lvl_mode;
    logic              ready;
    logic              init_pulse;
    logic              eoi_pulse;
    logic [LVL_W-1:0]  eoi_lvl;

    pic8_regif u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .a0         (a0),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .din        (din),
        .irr        (irr),
        .isr        (isr),
        .is_master  (is_master),
        .rd_data    (dout),
        .imr        (imr),
        .vec_base   (vec_base),
        .auto_eoi   (auto_eoi),
        .lvl_mode   (lvl_mode),
        .ready      (ready),
        .init_pulse (init_pulse),
        .eoi_pulse  (eoi_pulse),
        .eoi_lvl    (eoi_lvl),
        .cas_id     (cas_id)
    );

    pic8_irr u_irr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ir       (ir),
        .lvl_mode (lvl_mode),
        .clr_all  (init_pulse),
        .ack_clr  (ack_clr),
        .irr      (irr)
    );

    pic8_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .irr        (irr),
        .imr        (imr),
        .ready      (ready),
        .ack        (ack),
        .auto_eoi   (auto_eoi),
        .vec_base   (vec_base),
        .init_pulse (init_pulse),
        .eoi_pulse  (eoi_pulse),
        .eoi_lvl    (eoi_lvl),
        .isr        (isr),
        .ack_clr    (ack_clr),
        .intr       (intr),
        .vec        (vec),
        .vec_vld    (vec_vld)
    );
endmodule

// File: tb/tb_pic8_core.sv
// tb_pic8_core: scoreboard bench. do_ack queues the expected vector; a
// monitor pops and compares it whenever vec_vld is seen.
module tb_pic8_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, a0 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic [7:0] ir = '0;
    logic       ack = 1'b0;
    logic       is_master = 1'b1;
    logic       intr;
    logic [7:0] vec;
    logic       vec_vld;
    logic [2:0] cas_id;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] exp_q[$];

    pic8_core dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .a0(a0), .rd_n(rd_n),
        .wr_n(wr_n), .din(din), .dout(dout), .ir(ir), .ack(ack),
        .is_master(is_master), .intr(intr), .vec(vec), .vec_vld(vec_vld),
        .cas_id(cas_id)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; a0 = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic rd_chk(input string rq, input logic a, input logic [7:0] exp);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a0 = a;
        #1 chk(rq, dout, exp);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic do_ack(input logic [7:0] exp);
        exp_q.push_back(exp);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // scoreboard monitor: compare each produced vector with the queue head
    always @(negedge clk) begin
        if (rst_n && vec_vld) begin
            if (exp_q.size() == 0) chk("R3 unexpected vector", vec, 8'hxx);
            else chk("R3 vector", vec, exp_q.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 intr", {7'd0, intr}, 8'h00);
        chk("R1 vec_vld", {7'd0, vec_vld}, 8'h00);
        rd_chk("R1 mask", 1'b1, 8'hFF);
        rd_chk("R1 request", 1'b0, 8'h00);

        // before setup: capture works, no interrupt
        ir = 8'h08; cyc(3);
        rd_chk("R4 edge capture", 1'b0, 8'h08);
        chk("R2 quiet before setup", {7'd0, intr}, 8'h00);
        ir = 8'h00; cyc(2);
        rd_chk("R4 clear on low", 1'b0, 8'h00);
        wr(1'b1, 8'h00);

        // master setup, normal retirement
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        rd_chk("R2 mask kept", 1'b1, 8'h00);
        chk("R13 master id", {5'd0, cas_id}, 8'h00);

        ir = 8'h20; cyc(3);
        chk("R7 intr single", {7'd0, intr}, 8'h01);
        do_ack(8'h25);
        cyc(2);
        chk("R8 intr falls", {7'd0, intr}, 8'h00);
        wr(1'b0, 8'h0B);
        rd_chk("R8 in service", 1'b0, 8'h20);
        rd_chk("R10 persist", 1'b0, 8'h20);
        wr(1'b0, 8'h08);
        rd_chk("R10 no select", 1'b0, 8'h20);
        wr(1'b0, 8'h0A);
        rd_chk("R4 ack clears", 1'b0, 8'h00);
        ir = 8'h00;

        // nesting by priority
        ir = 8'h40; cyc(3);
        chk("R7 lower blocked", {7'd0, intr}, 8'h00);
        ir = 8'h44; cyc(3);
        chk("R7 higher nests", {7'd0, intr}, 8'h01);
        do_ack(8'h22);
        wr(1'b0, 8'h0B);
        rd_chk("R8 nested", 1'b0, 8'h24);
        wr(1'b0, 8'h62);
        rd_chk("R9 only level 2", 1'b0, 8'h20);
        cyc(2);
        chk("R7 still blocked", {7'd0, intr}, 8'h00);
        wr(1'b0, 8'h65); cyc(3);
        chk("R7 released", {7'd0, intr}, 8'h01);
        do_ack(8'h26);
        wr(1'b0, 8'h66);
        rd_chk("R9 all retired", 1'b0, 8'h00);
        ir = 8'h00;

        // masking
        wr(1'b1, 8'h10);
        ir = 8'h10; cyc(3);
        chk("R6 masked quiet", {7'd0, intr}, 8'h00);
        wr(1'b0, 8'h0A);
        rd_chk("R6 masked latched", 1'b0, 8'h10);
        wr(1'b1, 8'h00); cyc(3);
        chk("R6 unmasked", {7'd0, intr}, 8'h01);
        do_ack(8'h24);
        wr(1'b0, 8'h64);
        ir = 8'h00;

        // spurious with input 7 masked
        wr(1'b1, 8'h80);
        ir = 8'h02; cyc(3);
        chk("R12 intr raised", {7'd0, intr}, 8'h01);
        ir = 8'h00;
        do_ack(8'h27);
        wr(1'b0, 8'h0B);
        rd_chk("R12 no in-service", 1'b0, 8'h00);

        // re-setup clears in-service; automatic retirement
        wr(1'b1, 8'h00);
        ir = 8'h01; cyc(3);
        do_ack(8'h20);
        ir = 8'h00;
        rd_chk("R8 level 0 in service", 1'b0, 8'h01);
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
        wr(1'b0, 8'h0B);
        rd_chk("R2 in-service cleared", 1'b0, 8'h00);
        rd_chk("R2 mask kept again", 1'b1, 8'h00);
        ir = 8'h08; cyc(3);
        do_ack(8'h23);
        rd_chk("R11 nothing in service", 1'b0, 8'h00);
        cyc(2);
        chk("R11 intr low", {7'd0, intr}, 8'h00);
        ir = 8'h00;

        // level mode, single controller: cascade word skipped
        wr(1'b0, 8'h1B); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
        wr(1'b1, 8'h5A);
        rd_chk("R2 cascade word skipped", 1'b1, 8'h5A);
        wr(1'b1, 8'h00);
        ir = 8'h02; cyc(3);
        wr(1'b0, 8'h0A);
        rd_chk("R5 level follows", 1'b0, 8'h02);
        do_ack(8'h41);
        rd_chk("R5 held after ack", 1'b0, 8'h02);
        ir = 8'h00; cyc(2);
        rd_chk("R5 drops with input", 1'b0, 8'h00);
        wr(1'b0, 8'h0B);
        rd_chk("R8 level mode service", 1'b0, 8'h02);
        wr(1'b0, 8'h61);
        rd_chk("R9 retired", 1'b0, 8'h00);

        // subordinate setup
        is_master = 1'b0;
        wr(1'b0, 8'h11); wr(1'b1, 8'h70); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
        #1 chk("R13 own id", {5'd0, cas_id}, 8'h02);
        ir = 8'h08; cyc(3);
        do_ack(8'h73);
        is_master = 1'b1;
        #1 chk("R13 master zero", {5'd0, cas_id}, 8'h00);
        ir = 8'h00;

        cyc(3);
        chk("R3 queue drained", 8'(exp_q.size()), 8'h00);
        summary();
    end
endmodule